// File: doc/BRIEF.md
# Register-List Transfer Sequencer

This block runs the multi-word transfers of a 16-bit compressed instruction set. It handles two kinds of transfer. The stack kind pushes or pops a list of low registers, and can add the link register on a push or the program counter on a pop. The base-register kind stores or loads a list of registers at the address held in a chosen base register.

The sequencer takes the instruction word when `start` is pulsed. It reads the base (or the stack pointer) through a register-file read port, then issues one word access per cycle on a simple memory port, with the address stepping by 4. Register updates leave through two write ports:

- The writeback port carries the new base or stack pointer.
- The load port carries each word that comes back from memory.

When both ports write the same register in the same cycle, the register file applies the load port last. The register file and the memory sit outside the block.

States and transitions:

- `RLS_IDLE` goes to `RLS_BASE` on `start`.
- `RLS_BASE` reads the base or stack pointer, and on a push writes the decremented stack pointer. It goes to `RLS_XFER` when the list is not empty. Otherwise it goes to `RLS_LDIDLE` for a load, or to `RLS_DONE` for a store.
- `RLS_XFER` makes one access per cycle. After the last access it goes to `RLS_LDIDLE` for a load, or to `RLS_DONE` for a store.
- `RLS_LDIDLE` is the internal cycle after a load. It performs the pop writeback and goes to `RLS_DONE`.
- `RLS_DONE` raises `done` and returns to `RLS_IDLE`.

Top module: `rls_seq`

## Requirements
- R1: Instruction fields:
  - `instr[15:12]` = 4'hC selects base-register mode, with the base in `instr[10:8]`. Any other value selects stack mode, whose base is register 13.
  - `instr[11]` = 1 means load.
  - `instr[7:0]` bit i lists register i.
  - In stack mode, `instr[8]` adds register 14 to a store, or register 15 to a load.
- R2: Listed registers move in ascending index order, one word access per cycle. Each address is 4 above the previous one, and the bus address always has its two low bits at zero.
- R3: A push writes the stack pointer, decremented by 4 times the number of words, in the cycle before the first store. Stores then run upward from the new value, with register 14 at the highest address.
- R4: A pop loads upward from the stack pointer, with register 15 last. The stack pointer becomes old value plus 4 times the number of words, and is written in the idle cycle after the final load.
- R5: In base-register mode, base plus 4 times the count is written in the cycle of the first access. As a result:
  - A stored base that is the first listed register keeps its old value.
  - A stored base listed later takes the new value.
  - A loaded base takes the loaded word.
- R6: In base-register mode, an empty list moves only register 15, and the base still advances by 64.
- R7: Storing register 15 writes `pc_in` + 2.
- R8: `mem_seq` is 0 on the first access of a transfer and 1 on every later one.
- R9: A load has one idle cycle with no access after its last transfer.
- R10: Loaded words reach the register unchanged whatever the low base bits are. Writeback arithmetic uses the full, unaligned base.
- R11: `done` is a one-cycle pulse in the cycle after the last access (for a store) or after the idle cycle (for a load). Counting `start`'s capture edge as edge 0, `done` is seen after edge n+1 for a store of n words and after edge n+2 for a load. A `start` while `busy` is ignored.
- R12: After reset the block is idle: `busy`, `done`, `mem_req` and both write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| instr | input | 16 | Transfer instruction word |
| pc_in | input | ADDR_W | Current program counter |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | DATA_W | Register-file read data (same cycle) |
| rf_wb_we | output | 1 | Base/stack-pointer write enable |
| rf_wb_addr | output | 4 | Base/stack-pointer write index |
| rf_wb_data | output | DATA_W | Base/stack-pointer write value |
| rf_ld_we | output | 1 | Loaded-word write enable |
| rf_ld_addr | output | 4 | Loaded-word register index |
| rf_ld_data | output | DATA_W | Loaded word |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_seq | output | 1 | Access is sequential |
| mem_addr | output | ADDR_W | Word-aligned access address |
| mem_wdata | output | DATA_W | Store data |
| mem_rdata | input | DATA_W | Load data (same cycle) |

## Verification
Pushes and pops with and without the extra register tell the stack decrement and the final writeback apart from the base-register update. Stores in which the base is the first or a later listed register, and a load whose list contains the base, show exactly when writeback happens relative to the transfers. Empty lists in both modes and an unaligned base pin down the 64-byte advance, the `pc_in` + 2 store value, and the split between bus alignment and writeback arithmetic. A second `start` pulsed mid-transfer shows that it is ignored.

// File: rtl/rls_pkg.sv
package rls_pkg;
    typedef enum logic [2:0] {
        RLS_IDLE,
        RLS_BASE,
        RLS_XFER,
        RLS_LDIDLE,
        RLS_DONE
    } rls_state_e;

    localparam logic [3:0] MULTI_CLASS  = 4'hC;
    localparam int         SP_IDX       = 13;
    localparam int         LR_IDX       = 14;
    localparam int         PC_IDX       = 15;
    localparam int         PC_STORE_ADJ = 2;
endpackage

// File: rtl/rls_decode.sv
module rls_decode
    import rls_pkg::*;
#(
    parameter int LIST_W = 8,
    parameter int REG_N  = 16,
    parameter int CNT_W  = $clog2(REG_N + 1)
) (
    input  logic [15:0]              instr,
    output logic                     multi,
    output logic                     load,
    output logic [$clog2(REG_N)-1:0] base_idx,
    output logic [REG_N-1:0]         eff_mask,
    output logic [CNT_W-1:0]         count
);
    localparam int IW = $clog2(REG_N);

    logic [LIST_W-1:0] list;
    logic              extra;
    logic              empty_multi;

    assign list        = instr[LIST_W-1:0];
    assign multi       = (instr[15:12] == MULTI_CLASS);
    assign load        = instr[11];
    assign extra       = !multi && instr[8];
    assign empty_multi = multi && (list == '0);
    assign base_idx    = multi ? IW'(instr[10:8]) : IW'(SP_IDX);

    // Effective mask: listed low registers plus LR/PC extras.
    always_comb begin
        eff_mask = '0;
        eff_mask[LIST_W-1:0] = list;
        if (empty_multi) begin
            eff_mask[PC_IDX] = 1'b1;
        end
        if (extra) begin
            if (load) begin
                eff_mask[PC_IDX] = 1'b1;
            end else begin
                eff_mask[LR_IDX] = 1'b1;
            end
        end
    end

    // Word count used for address span (empty multi list counts as REG_N).
    always_comb begin
        if (empty_multi) begin
            count = CNT_W'(REG_N);
        end else begin
            count = CNT_W'($countones(list)) + CNT_W'(extra);
        end
    end
endmodule

// File: rtl/rls_pick.sv
module rls_pick #(
    parameter int N = 16
) (
    input  logic [N-1:0]         mask,
    output logic [$clog2(N)-1:0] idx,
    output logic [N-1:0]         rest
);
    localparam int IW = $clog2(N);

    logic [N-1:0] low_one;

    assign low_one = mask & (~mask + N'(1));
    assign rest    = mask & ~low_one;

    generate
        for (genvar b = 0; b < IW; b++) begin : g_bit
            logic [N-1:0] sel;
            for (genvar i = 0; i < N; i++) begin : g_pos
                assign sel[i] = ((i >> b) % 2) == 1;
            end
            assign idx[b] = |(low_one & sel);
        end
    endgenerate
endmodule

// File: rtl/rls_seq.sv
module rls_seq
    import rls_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LIST_W = 8,
    parameter int REG_N  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [15:0]              instr,
    input  logic [ADDR_W-1:0]        pc_in,
    output logic                     busy,
    output logic                     done,
    output logic [$clog2(REG_N)-1:0] rf_raddr,
    input  logic [DATA_W-1:0]        rf_rdata,
    output logic                     rf_wb_we,
    output logic [$clog2(REG_N)-1:0] rf_wb_addr,
    output logic [DATA_W-1:0]        rf_wb_data,
    output logic                     rf_ld_we,
    output logic [$clog2(REG_N)-1:0] rf_ld_addr,
    output logic [DATA_W-1:0]        rf_ld_data,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic                     mem_seq,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata
);
    localparam int IW     = $clog2(REG_N);
    localparam int CNT_W  = $clog2(REG_N + 1);
    localparam int WORD_B = DATA_W / 8;

    rls_state_e        state_q, state_d;
    logic [15:0]       instr_q;
    logic [REG_N-1:0]  mask_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wbval_q;
    logic              first_q;

    logic              multi, load, push;
    logic [IW-1:0]     base_idx;
    logic [REG_N-1:0]  eff_mask;
    logic [CNT_W-1:0]  count;
    logic [IW-1:0]     cur_idx;
    logic [REG_N-1:0]  rest;
    logic [ADDR_W-1:0] base_rd, span;

    rls_decode #(.LIST_W(LIST_W), .REG_N(REG_N), .CNT_W(CNT_W)) u_decode (
        .instr    (instr_q),
        .multi    (multi),
        .load     (load),
        .base_idx (base_idx),
        .eff_mask (eff_mask),
        .count    (count)
    );

    rls_pick #(.N(REG_N)) u_pick (
        .mask (mask_q),
        .idx  (cur_idx),
        .rest (rest)
    );

    assign push    = !multi && !load;
    assign base_rd = ADDR_W'(rf_rdata);
    assign span    = ADDR_W'(count) * ADDR_W'(WORD_B);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RLS_IDLE:   if (start) state_d = RLS_BASE;
            RLS_BASE: begin
                if (eff_mask != '0)  state_d = RLS_XFER;
                else if (load)       state_d = RLS_LDIDLE;
                else                 state_d = RLS_DONE;
            end
            RLS_XFER: begin
                if (rest == '0) state_d = load ? RLS_LDIDLE : RLS_DONE;
            end
            RLS_LDIDLE: state_d = RLS_DONE;
            RLS_DONE:   state_d = RLS_IDLE;
            default:    state_d = RLS_IDLE;
        endcase
    end

    // State register and transfer bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RLS_IDLE;
            instr_q <= '0;
            mask_q  <= '0;
            addr_q  <= '0;
            wbval_q <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                RLS_IDLE: begin
                    if (start) instr_q <= instr;
                end
                RLS_BASE: begin
                    mask_q  <= eff_mask;
                    addr_q  <= push ? (base_rd - span) : base_rd;
                    wbval_q <= push ? (base_rd - span) : (base_rd + span);
                    first_q <= 1'b1;
                end
                RLS_XFER: begin
                    mask_q  <= rest;
                    addr_q  <= addr_q + ADDR_W'(WORD_B);
                    first_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Output logic
    always_comb begin
        busy       = (state_q != RLS_IDLE);
        done       = 1'b0;
        rf_raddr   = base_idx;
        rf_wb_we   = 1'b0;
        rf_wb_addr = base_idx;
        rf_wb_data = DATA_W'(wbval_q);
        rf_ld_we   = 1'b0;
        rf_ld_addr = cur_idx;
        rf_ld_data = mem_rdata;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_seq    = 1'b0;
        mem_addr   = addr_q & ~ADDR_W'(WORD_B - 1);
        mem_wdata  = rf_rdata;
        unique case (state_q)
            RLS_IDLE: ;
            RLS_BASE: begin
                rf_raddr   = base_idx;
                rf_wb_we   = push;
                rf_wb_data = DATA_W'(base_rd - span);
            end
            RLS_XFER: begin
                rf_raddr = cur_idx;
                mem_req  = 1'b1;
                mem_we   = !load;
                mem_seq  = !first_q;
                rf_ld_we = load;
                rf_wb_we = multi && first_q;
                if (cur_idx == IW'(PC_IDX)) begin
                    mem_wdata = DATA_W'(pc_in + ADDR_W'(PC_STORE_ADJ));
                end
            end
            RLS_LDIDLE: begin
                rf_wb_we = !multi;
            end
            RLS_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // Consecutive accesses step by one word.
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req) |-> mem_addr == $past(mem_addr) + ADDR_W'(WORD_B));

    // First access of a burst is non-sequential.
    assert_first_nonseq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !$past(mem_req) |-> !mem_seq);

    // Later accesses are sequential.
    assert_later_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req) |-> mem_seq);

    // Loaded words are only written while a read is on the bus.
    assert_ld_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_ld_we |-> mem_req && !mem_we);

    // After the last load there is an idle cycle before done.
    assert_load_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) && $past(!mem_we) |-> !done && !mem_req);

    // Done lasts one cycle.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/test_rls_seq.sv
module test_rls_seq;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] instr;
    logic [31:0] pc_in;
    logic        busy, done;
    logic [3:0]  rf_raddr, rf_wb_addr, rf_ld_addr;
    logic [31:0] rf_rdata, rf_wb_data, rf_ld_data;
    logic        rf_wb_we, rf_ld_we;
    logic        mem_req, mem_we, mem_seq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] rf  [16];
    logic [31:0] mem [256];

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          finished = 0;

    int          log_n;
    logic [31:0] log_addr [32];
    logic        log_seq  [32];
    logic        log_we   [32];
    logic [31:0] log_sp   [32];

    always #(CLK_P/2) clk = ~clk;

    rls_seq i_rls_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in),
        .busy(busy), .done(done),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_wb_we(rf_wb_we), .rf_wb_addr(rf_wb_addr), .rf_wb_data(rf_wb_data),
        .rf_ld_we(rf_ld_we), .rf_ld_addr(rf_ld_addr), .rf_ld_data(rf_ld_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_seq(mem_seq),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = mem[mem_addr[9:2]];

    // Register file and memory models; load port applied after writeback port.
    always @(posedge clk) begin
        if (mem_req && log_n < 32) begin
            log_addr[log_n] = mem_addr;
            log_seq[log_n]  = mem_seq;
            log_we[log_n]   = mem_we;
            log_sp[log_n]   = rf[13];
            log_n = log_n + 1;
        end
        if (rf_wb_we) rf[rf_wb_addr] <= rf_wb_data;
        if (rf_ld_we) rf[rf_ld_addr] <= rf_ld_data;
        if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_state();
        for (int i = 0; i < 16; i++) rf[i] = 32'h0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    endtask

    task automatic run(input logic [15:0] ins, input logic [31:0] pc, output int lat);
        @(negedge clk);
        instr = ins;
        pc_in = pc;
        start = 1'b1;
        log_n = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R12", "busy", {31'b0, busy}, 32'h0);
        check("R12", "done", {31'b0, done}, 32'h0);
        check("R12", "mem_req", {31'b0, mem_req}, 32'h0);
        check("R12", "write enables", {30'b0, rf_wb_we, rf_ld_we}, 32'h0);
    endtask

    task automatic t_push();
        int lat;
        clear_state();
        rf[13] = 32'h100; rf[0] = 32'h1111_0000; rf[2] = 32'h2222_0000; rf[14] = 32'hEEEE_0001;
        run(16'hB505, 32'h0, lat);
        check("R3", "push sp", rf[13], 32'h0F4);
        check("R3", "sp ready at first store", log_sp[0], 32'h0F4);
        check("R3", "R0 slot", mem[32'h0F4 >> 2], 32'h1111_0000);
        check("R3", "R2 slot", mem[32'h0F8 >> 2], 32'h2222_0000);
        check("R3", "LR slot", mem[32'h0FC >> 2], 32'hEEEE_0001);
        check("R2", "push count", log_n, 3);
        check("R2", "push addr2", log_addr[2], 32'h0FC);
        check("R8", "push seq", {29'b0, log_seq[0], log_seq[1], log_seq[2]}, 32'h3);
        check("R11", "push latency", lat, 5);
    endtask

    task automatic t_pop();
        int lat;
        clear_state();
        rf[13] = 32'h200;
        mem[32'h200 >> 2] = 32'hA0A0_0001; mem[32'h204 >> 2] = 32'hB0B0_0002; mem[32'h208 >> 2] = 32'hC0C0_0003;
        run(16'hBD0A, 32'h0, lat);
        check("R4", "pop R1", rf[1], 32'hA0A0_0001);
        check("R4", "pop R3", rf[3], 32'hB0B0_0002);
        check("R4", "pop PC last", rf[15], 32'hC0C0_0003);
        check("R4", "pop sp", rf[13], 32'h20C);
        check("R4", "sp unchanged during loads", log_sp[2], 32'h200);
        check("R1", "pop reads", {31'b0, log_we[0]}, 32'h0);
        check("R9", "pop latency", lat, 6);
    endtask

    task automatic t_stm_base_first();
        int lat;
        clear_state();
        rf[2] = 32'h300; rf[5] = 32'h55;
        run(16'hC224, 32'h0, lat);
        check("R5", "old base stored", mem[32'h300 >> 2], 32'h300);
        check("R5", "R5 stored", mem[32'h304 >> 2], 32'h55);
        check("R5", "base writeback", rf[2], 32'h308);
        check("R11", "stm latency", lat, 4);
    endtask

    task automatic t_stm_base_later();
        int lat;
        clear_state();
        rf[1] = 32'h340; rf[0] = 32'h99;
        run(16'hC103, 32'h0, lat);
        check("R5", "R0 stored", mem[32'h340 >> 2], 32'h99);
        check("R5", "new base stored", mem[32'h344 >> 2], 32'h348);
        check("R5", "base writeback", rf[1], 32'h348);
    endtask

    task automatic t_ldm_load_wins();
        int lat;
        clear_state();
        rf[3] = 32'h380;
        mem[32'h380 >> 2] = 32'h0000_AAAA; mem[32'h384 >> 2] = 32'h0000_BBBB;
        run(16'hCB18, 32'h0, lat);
        check("R5", "loaded base wins", rf[3], 32'h0000_AAAA);
        check("R5", "R4 loaded", rf[4], 32'h0000_BBBB);
        check("R9", "ldm latency", lat, 5);
    endtask

    task automatic t_empty_lists();
        int lat;
        clear_state();
        rf[4] = 32'h100; mem[32'h100 >> 2] = 32'h1234_5678;
        run(16'hCC00, 32'h0, lat);
        check("R6", "empty load PC", rf[15], 32'h1234_5678);
        check("R6", "empty load base +64", rf[4], 32'h140);
        check("R6", "empty load one access", log_n, 1);
        clear_state();
        rf[5] = 32'h3C0;
        run(16'hC500, 32'h0800_0010, lat);
        check("R7", "stored PC+2", mem[32'h3C0 >> 2], 32'h0800_0012);
        check("R6", "empty store base +64", rf[5], 32'h400);
        check("R6", "empty store latency", lat, 3);
        clear_state();
        rf[13] = 32'h180;
        run(16'hB400, 32'h0, lat);
        check("R3", "empty push no access", log_n, 0);
        check("R3", "empty push sp", rf[13], 32'h180);
        check("R11", "empty push latency", lat, 2);
        run(16'hBC00, 32'h0, lat);
        check("R4", "empty pop sp", rf[13], 32'h180);
        check("R9", "empty pop latency", lat, 3);
    endtask

    task automatic t_unaligned();
        int lat;
        clear_state();
        rf[6] = 32'h1C2; mem[32'h1C0 >> 2] = 32'hCAFE_F00D;
        run(16'hCE01, 32'h0, lat);
        check("R2", "aligned bus addr", log_addr[0], 32'h1C0);
        check("R10", "unrotated word", rf[0], 32'hCAFE_F00D);
        check("R10", "unaligned writeback", rf[6], 32'h1C6);
    endtask

    task automatic t_start_while_busy();
        int lat;
        clear_state();
        rf[1] = 32'h200; rf[7] = 32'h77;
        @(negedge clk);
        instr = 16'hC10F; pc_in = 32'h0; start = 1'b1; log_n = 0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        instr = 16'hC700; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        repeat (5) @(negedge clk);
        check("R11", "second start ignored count", log_n, 4);
        check("R11", "second start base untouched", rf[7], 32'h77);
        check("R11", "first transfer writeback", rf[1], 32'h210);
        check("R11", "idle again", {31'b0, busy}, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; instr = 16'h0; pc_in = 32'h0; log_n = 0;
        clear_state();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_push();
        t_pop();
        t_stm_base_first();
        t_stm_base_later();
        t_ldm_load_wins();
        t_empty_lists();
        t_unaligned();
        t_start_while_busy();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule